// File: doc/BRIEF.md
# Three-Lane Word Serializer with Forwarded Clock

This block turns a 21-bit parallel word into three serial bit streams and a fourth stream that carries a clock. A slow word clock marks each new word. The block runs on a fast bit clock that is seven times the word rate and synchronous to it. On each rising edge of the word clock the block captures the word. It then shifts one 7-bit slice out on each data lane, least-significant bit first. A receiver uses the fourth lane, which toggles once per word, to find the word boundaries.

A single active-low shutdown input clears the block and silences every output at once, without waiting for a clock edge. After shutdown is released, the lanes stay at zero until the first new word has been captured and loaded. Stale data is therefore never sent.

Top module: `tri_lane_ser`

## Requirements
- R1: `par_in` is captured at the rising edge of `bit_clk` that first sees `word_clk` high after it was low. Changes of `par_in` on any other edge have no effect on what is sent.
- R2: Lane `ser_out[g]` carries bits `7g` to `7g+6` of the captured word. Lane 0 carries bits 0..6, lane 1 carries bits 7..13 and lane 2 carries bits 14..20.
- R3: Each lane sends exactly seven bits per word, least-significant bit of its slice first, one bit per `bit_clk` cycle.
- R4: Bit 0 of a word appears on the lanes after the second `bit_clk` rising edge that follows the capture edge. Counted from the capture edge itself, that is two edges.
- R5: `fwd_clk` is high for the first four bit times of each word and low for the last three. It rises together with bit 0.
- R6: While `shdn_n` is low, `ser_out` and `fwd_clk` are 0 at all times, independent of `bit_clk`.
- R7: After `shdn_n` rises, `ser_out` and `fwd_clk` stay 0 until the first word captured after the release is loaded. A `word_clk` that is already high at release is not taken as an edge.
- R8: Back-to-back words follow each other with no gap bit: bit 6 of one word is followed directly by bit 0 of the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Fast bit clock, seven times the word rate |
| shdn_n | input | 1 | Active-low shutdown; asynchronous clear of all state |
| word_clk | input | 1 | Word clock, synchronous to `bit_clk`, one period per 7 bit clocks |
| par_in | input | 21 | Parallel word to send |
| ser_out | output | 3 | Serial data lanes, one per 7-bit slice |
| fwd_clk | output | 1 | Forwarded clock lane, high 4 bit times, low 3 |

## Verification
The assertions assume that `word_clk` changes only between `bit_clk` edges and has exactly one rising edge every seven bit clocks. They also assume that `par_in` is settled at the edge that first sees the new high level. The stimulus makes `word_clk` high for four bit clocks and low for three, and always changes it on falling edges. Between capture edges it fills `par_in` with unrelated values. `shdn_n` is moved a quarter period after a falling edge, so it never coincides with a rising edge. At release `word_clk` is held high, to test that a level already high is not mistaken for an edge.

// File: rtl/tri_lane_ser.sv
module tri_lane_ser #(
  parameter int LANES  = 3,
  parameter int SLICE  = 7,
  parameter int CLK_HI = 4
) (
  input  logic                     bit_clk,
  input  logic                     shdn_n,
  input  logic                     word_clk,
  input  logic [LANES*SLICE-1:0]   par_in,
  output logic [LANES-1:0]         ser_out,
  output logic                     fwd_clk
);
  localparam int WORD = LANES * SLICE;
  localparam int PW   = $clog2(SLICE);

  logic            wclk_q;
  logic [WORD-1:0] word_q;
  logic [PW-1:0]   phase;
  logic            have_word;
  logic            live;

  wire capture = word_clk & ~wclk_q;
  wire at_load = (phase == '0);

  always_ff @(posedge bit_clk or negedge shdn_n) begin
    if (!shdn_n) begin
      wclk_q    <= 1'b1;
      word_q    <= '0;
      phase     <= '0;
      have_word <= 1'b0;
      live      <= 1'b0;
    end else begin
      wclk_q <= word_clk;
      if (capture) begin
        word_q    <= par_in;
        have_word <= 1'b1;
      end
      if (capture || phase == PW'(SLICE - 1)) phase <= '0;
      else                                    phase <= phase + 1'b1;
      if (at_load && have_word) live <= 1'b1;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [SLICE-1:0] sh;
    always_ff @(posedge bit_clk or negedge shdn_n) begin
      if (!shdn_n)      sh <= '0;
      else if (at_load) sh <= word_q[g*SLICE +: SLICE];
      else              sh <= {1'b0, sh[SLICE-1:1]};
    end
    assign ser_out[g] = live & sh[0];
  end

  assign fwd_clk = live && (phase != '0) && (phase <= PW'(CLK_HI));
endmodule

// File: rtl/tri_lane_ser_chk.sv
module tri_lane_ser_chk #(
  parameter int LANES  = 3,
  parameter int SLICE  = 7,
  parameter int CLK_HI = 4
) (
  input logic                     bit_clk,
  input logic                     shdn_n,
  input logic                     capture,
  input logic                     have_word,
  input logic [LANES*SLICE-1:0]   par_in,
  input logic [LANES*SLICE-1:0]   word_q,
  input logic [LANES-1:0]         ser_out,
  input logic                     fwd_clk,
  input logic [$clog2(SLICE)-1:0] phase
);
  logic [7:0] run;
  always_ff @(posedge bit_clk or negedge shdn_n)
    if (!shdn_n) run <= '0;
    else         run <= fwd_clk ? run + 8'd1 : 8'd0;

  AST_CAPTURE_WORD: assert property (@(posedge bit_clk) disable iff (!shdn_n)
    capture |=> word_q == $past(par_in)); // R1
  AST_PHASE_IN_RANGE: assert property (@(posedge bit_clk) disable iff (!shdn_n)
    phase < ($clog2(SLICE))'(SLICE)); // R3
  AST_FWD_HIGH_LEN: assert property (@(posedge bit_clk) disable iff (!shdn_n)
    $fell(fwd_clk) |-> run == 8'(CLK_HI)); // R5
  AST_QUIET_IN_SHUTDOWN: assert property (@(posedge bit_clk)
    !shdn_n |-> (ser_out == '0 && !fwd_clk)); // R6
  AST_SILENT_UNTIL_WORD: assert property (@(posedge bit_clk) disable iff (!shdn_n)
    !have_word |-> (ser_out == '0 && !fwd_clk)); // R7
endmodule

bind tri_lane_ser tri_lane_ser_chk #(.LANES(LANES), .SLICE(SLICE), .CLK_HI(CLK_HI)) u_chk (.*);

// File: tb/tri_lane_ser_bench.sv
module tri_lane_ser_bench;
  localparam int CLK_T = 10;
  localparam int SL    = 7;

  logic        bit_clk = 1'b0;
  logic        shdn_n  = 1'b0;
  logic        word_clk = 1'b0;
  logic [20:0] par_in  = '0;
  logic [2:0]  ser_out;
  logic        fwd_clk;

  tri_lane_ser u_tri_lane_ser (.bit_clk(bit_clk), .shdn_n(shdn_n), .word_clk(word_clk),
                               .par_in(par_in), .ser_out(ser_out), .fwd_clk(fwd_clk));

  always #(CLK_T/2) bit_clk = ~bit_clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  logic [20:0] q_word[$];
  int          q_cyc[$];
  logic [31:0] lfsr = 32'h1234_5678;

  always @(posedge bit_clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [20:0] garbage();
    lfsr = lfsr * 32'd1664525 + 32'd1013904223;
    return lfsr[28:8];
  endfunction

  // driver: one word per 7 bit clocks, junk on par_in away from capture (R1)
  task automatic drive_word(input logic [20:0] d);
    @(negedge bit_clk);
    word_clk = 1'b1; par_in = d;
    q_word.push_back(d); q_cyc.push_back(cyc + 2);
    repeat (3) begin @(negedge bit_clk); par_in = garbage(); end
    @(negedge bit_clk); word_clk = 1'b0; par_in = garbage();
    repeat (2) begin @(negedge bit_clk); par_in = garbage(); end
  endtask

  task automatic shutdown(input int hold);
    repeat (2) @(negedge bit_clk);
    #(CLK_T/4) shdn_n = 1'b0;
    q_word.delete(); q_cyc.delete();
    @(negedge bit_clk); word_clk = 1'b1;
    repeat (hold) @(negedge bit_clk);
    #(CLK_T/4) shdn_n = 1'b1;
    repeat (2) @(negedge bit_clk);
    @(negedge bit_clk); word_clk = 1'b0;
    repeat (2) @(negedge bit_clk);
  endtask

  // monitor / scoreboard
  int          idx = -1;
  logic [20:0] cur;
  always @(negedge bit_clk) begin
    if (!shdn_n) begin
      idx = -1;
      chk(ser_out == 3'b0 && !fwd_clk, "R6 quiet in shutdown", {ser_out, fwd_clk}, 0);
    end else begin
      if (idx < 0) begin
        if (fwd_clk) begin
          if (q_word.size() == 0) chk(1'b0, "R7 unexpected word", 1, 0);
          else begin
            int ec;
            cur = q_word.pop_front(); ec = q_cyc.pop_front();
            chk(cyc == ec, "R4 first bit latency", cyc, ec);
            idx = 0;
          end
        end else
          chk(ser_out == 3'b0, "R7 lanes idle", ser_out, 0);
      end
      if (idx >= 0) begin
        logic [2:0] e;
        for (int l = 0; l < 3; l++) e[l] = cur[l*SL + idx];
        chk(ser_out == e, $sformatf("R2 R3 bit %0d", idx), ser_out, e);
        chk(fwd_clk == (idx < 4), "R5 forwarded clock", fwd_clk, idx < 4);
        idx++;
        if (idx == SL) idx = -1;
      end
    end
  end

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (5) @(negedge bit_clk);
    #(CLK_T/4) shdn_n = 1'b1;
    repeat (4) @(negedge bit_clk);
    drive_word(21'h000000);
    drive_word(21'h1FFFFF);
    for (int b = 0; b < 21; b += 3) drive_word(21'(1) << b);
    drive_word(21'h155555);
    drive_word(21'h0AAAAA);
    drive_word(21'h00007F);
    drive_word(21'h1FC000);
    shutdown(5);
    for (int k = 0; k < 12; k++) drive_word(garbage());
    shutdown(3);
    drive_word(21'h13579B);
    drive_word(21'h02468A);
    for (int k = 0; k < 8; k++) drive_word(garbage());
    repeat (2) @(negedge bit_clk);
    #(CLK_T/4) shdn_n = 1'b0;
    @(negedge bit_clk);
    chk(q_word.size() == 0, "R8 all words delivered back-to-back", q_word.size(), 0);
    repeat (2) @(negedge bit_clk);
    done = 1;
    report();
  end

  initial begin
    repeat (5000) @(posedge bit_clk);
    if (!done) begin
      chk(1'b0, "watchdog", cyc, 0);
      report();
    end
  end
endmodule